// File: doc/BRIEF.md
# Stem-Cell Configuration Stream Decoder

This block is the control machine of a stem cell in a grid of single-bit logic cells. One upstream neighbour feeds it a serial stream, one bit per valid/ready handshake, and the block reads that stream as construction commands. A 3-bit face code from 1 to 6 turns that neighbour into a stem cell. The block then relays every later upstream bit to it, unchanged, until the neighbour raises its completion flag. Because every cell holds back its own configuration until its children are done, a circuit is grown along a path and programmed from the far end backwards. The relay can end on any child, so the stream can also walk a spanning tree and backtrack.

A face code of 000 ends the spawning phase for this cell. The block then reads a 15-bit configuration word, most significant bit first. The word holds a 3-bit cell type, two 3-bit input faces and a 6-bit output face mask. The word is committed to the function register in a single cycle, and completion is reported upstream. A cell configured as a stem goes back to decoding a new stream. Any other cell type freezes the block until reset.

The machine has four states. `ST_DIR` gathers a 3-bit face code. `ST_FWD` relays bits to the spawned neighbour. `ST_CFG` gathers the configuration word. `ST_HOLD` is the frozen, configured cell. The transitions are:
- `ST_DIR`→`ST_FWD` on a code from 1 to 6.
- `ST_DIR`→`ST_DIR` on code 7, which is discarded.
- `ST_DIR`→`ST_CFG` on code 0.
- `ST_FWD`→`ST_DIR` when the neighbour reports done.
- `ST_CFG`→`ST_DIR` when the committed type is stem.
- `ST_CFG`→`ST_HOLD` for any other type.
- Reset returns the machine to `ST_DIR`.

Top module: `stem_stream_decoder`

## Requirements
- R1: After reset, `up_ready` is 1, and `dn_valid`, `dn_spawn`, `up_done` and `cfg_we` are 0. All configuration outputs are 0.
- R2: In direction decode, three accepted bits, MSB first, form a face code. A code from 1 to 6 sets `dn_sel` to that code and raises `dn_spawn` for exactly the one cycle after the third bit is accepted.
- R3: While relaying, `dn_valid` follows `up_valid`, `dn_bit` equals `up_bit`, and `up_ready` follows `dn_ready`, so a full downstream link stalls the upstream link. Outside relaying, `dn_valid` stays 0.
- R4: While relaying, a cycle with `dn_done` high accepts no upstream bit and relays nothing. The block then returns to direction decode with `up_ready` at 1.
- R5: Face code 7 is discarded. It causes no spawn, and the block stays in direction decode.
- R6: After face code 0, the block accepts 15 bits, MSB first. They form a word with the type in bits 14:12, the first input face in 11:9, the second input face in 8:6 and the output mask in 5:0. After the 15th bit, the outputs `cfg_type`, `cfg_in0`, `cfg_in1` and `cfg_out` carry this word, and `cfg_we` and `up_done` are both high for exactly one cycle. An input face of 7 means the input is unused and is stored as given.
- R7: The configuration outputs keep their previous values while a word is being received. They change only at the commit.
- R8: Cell types are coded AND=0, NAND=1, OR=2, XOR=3, crossover=4, copy=5, delete=6 and stem=7. After a commit of type 7, the block returns to direction decode and accepts a new stream.
- R9: After a commit of any type other than 7, `up_ready` and `dn_valid` stay 0 and the configuration outputs stay stable until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream bit is offered |
| up_bit | input | 1 | Upstream data bit |
| up_ready | output | 1 | Block accepts the upstream bit this cycle |
| up_done | output | 1 | One-cycle completion report to upstream |
| dn_sel | output | 3 | Face of the spawned neighbour (1 to 6) |
| dn_spawn | output | 1 | One-cycle request that turns the selected neighbour into a stem cell |
| dn_valid | output | 1 | Relayed bit is offered downstream |
| dn_bit | output | 1 | Relayed data bit |
| dn_ready | input | 1 | Downstream link can take a bit |
| dn_done | input | 1 | Spawned neighbour reports completion |
| cfg_we | output | 1 | One-cycle strobe on commit of a new configuration |
| cfg_type | output | 3 | Committed cell type |
| cfg_in0 | output | 3 | Committed first input face (7 = unused) |
| cfg_in1 | output | 3 | Committed second input face (7 = unused) |
| cfg_out | output | 6 | Committed output face mask |

## Verification
The bench builds the block with its defaults: 3-bit face codes and a 6-bit output mask. This gives a 15-bit configuration word, and every face code can be sent, including the reserved 0 and 7. All eight cell types are then reachable, so both the stem return path and the frozen path are exercised. Random runs nest spawns with random relay lengths and random downstream stalls before each self-configuration. Directed cases cover a spawn ended with no relayed bit, a discarded code 7, and a word of unused input faces with a full output mask.

// File: rtl/stem_pkg.sv
package stem_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TYPE_W = 3;

    typedef enum logic [1:0] {
        ST_DIR,
        ST_FWD,
        ST_CFG,
        ST_HOLD
    } st_e;

    typedef enum logic [TYPE_W-1:0] {
        CT_AND   = 3'd0,
        CT_NAND  = 3'd1,
        CT_OR    = 3'd2,
        CT_XOR   = 3'd3,
        CT_CROSS = 3'd4,
        CT_COPY  = 3'd5,
        CT_DEL   = 3'd6,
        CT_STEM  = 3'd7
    } cell_e;
endpackage

// File: rtl/stem_shift.sv
// Serial field collector: holds the bits accepted so far and their count.
module stem_shift #(
    parameter int W  = 14,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          bit_in,
    output logic [W-1:0]  data,
    output logic [CW-1:0] count
);
    timeunit 1ns;
    timeprecision 1ps;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            data  <= '0;
            count <= '0;
        end else if (en) begin
            data  <= {data[W-2:0], bit_in};
            count <= count + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= W); // R6
endmodule

// File: rtl/stem_cfg_reg.sv
// Function register: loads the whole configuration word in one cycle.
module stem_cfg_reg #(
    parameter int TW = 3,
    parameter int DW = 3,
    parameter int OW = 6,
    localparam int CW = TW + 2*DW + OW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] din,
    output logic          we,
    output logic [TW-1:0] ctype,
    output logic [DW-1:0] in0,
    output logic [DW-1:0] in1,
    output logic [OW-1:0] outm
);
    timeunit 1ns;
    timeprecision 1ps;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we    <= 1'b0;
            ctype <= '0;
            in0   <= '0;
            in1   <= '0;
            outm  <= '0;
        end else begin
            we <= load;
            if (load) begin
                ctype <= din[CW-1 -: TW];
                in0   <= din[CW-TW-1 -: DW];
                in1   <= din[CW-TW-DW-1 -: DW];
                outm  <= din[OW-1:0];
            end
        end
    end
endmodule

// File: rtl/stem_stream_decoder.sv
module stem_stream_decoder #(
    parameter int DIR_W = 3,
    parameter int OUT_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     up_valid,
    input  logic                     up_bit,
    output logic                     up_ready,
    output logic                     up_done,
    output logic [DIR_W-1:0]         dn_sel,
    output logic                     dn_spawn,
    output logic                     dn_valid,
    output logic                     dn_bit,
    input  logic                     dn_ready,
    input  logic                     dn_done,
    output logic                     cfg_we,
    output logic [stem_pkg::TYPE_W-1:0] cfg_type,
    output logic [DIR_W-1:0]         cfg_in0,
    output logic [DIR_W-1:0]         cfg_in1,
    output logic [OUT_W-1:0]         cfg_out
);
    timeunit 1ns;
    timeprecision 1ps;
    import stem_pkg::*;

    localparam int CFG_W = TYPE_W + 2*DIR_W + OUT_W;
    localparam int CNT_W = $clog2(CFG_W);

    st_e                st_q, st_nx;
    logic               accept;
    logic               sh_en, sh_clr, load, spawn_nx;
    logic [CFG_W-2:0]   sh_data;
    logic [CNT_W-1:0]   sh_cnt;
    logic [CFG_W-1:0]   word_nx;
    logic [DIR_W-1:0]   code_nx;
    logic               last_dir, last_cfg, type_stem;

    assign accept    = up_valid && up_ready;
    assign word_nx   = {sh_data, up_bit};
    assign code_nx   = word_nx[DIR_W-1:0];
    assign last_dir  = (sh_cnt == CNT_W'(DIR_W-1));
    assign last_cfg  = (sh_cnt == CNT_W'(CFG_W-1));
    assign type_stem = (word_nx[CFG_W-1 -: TYPE_W] == CT_STEM);

    stem_shift #(.W(CFG_W-1), .CW(CNT_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .en(sh_en),
        .bit_in(up_bit), .data(sh_data), .count(sh_cnt)
    );

    stem_cfg_reg #(.TW(TYPE_W), .DW(DIR_W), .OW(OUT_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .load(load), .din(word_nx),
        .we(cfg_we), .ctype(cfg_type), .in0(cfg_in0), .in1(cfg_in1),
        .outm(cfg_out)
    );

    // Next-state decode
    always_comb begin
        st_nx    = st_q;
        sh_en    = 1'b0;
        sh_clr   = 1'b0;
        load     = 1'b0;
        spawn_nx = 1'b0;
        unique case (st_q)
            ST_DIR: if (accept) begin
                sh_en = 1'b1;
                if (last_dir) begin
                    sh_clr = 1'b1;
                    if (code_nx == '0) begin
                        st_nx = ST_CFG;
                    end else if (code_nx != '1) begin
                        st_nx    = ST_FWD;
                        spawn_nx = 1'b1;
                    end
                end
            end
            ST_FWD: if (dn_done) st_nx = ST_DIR;
            ST_CFG: if (accept) begin
                sh_en = 1'b1;
                if (last_cfg) begin
                    sh_clr = 1'b1;
                    load   = 1'b1;
                    st_nx  = type_stem ? ST_DIR : ST_HOLD;
                end
            end
            ST_HOLD: st_nx = ST_HOLD;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_DIR;
            dn_sel   <= '0;
            dn_spawn <= 1'b0;
            up_done  <= 1'b0;
        end else begin
            st_q     <= st_nx;
            dn_spawn <= spawn_nx;
            up_done  <= load;
            if (spawn_nx) dn_sel <= code_nx;
        end
    end

    // Link outputs
    always_comb begin
        up_ready = 1'b0;
        dn_valid = 1'b0;
        dn_bit   = up_bit;
        unique case (st_q)
            ST_DIR, ST_CFG: up_ready = 1'b1;
            ST_FWD: begin
                up_ready = dn_ready && !dn_done;
                dn_valid = up_valid && !dn_done;
            end
            ST_HOLD: up_ready = 1'b0;
        endcase
    end

    AST_DONE_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
        up_done |-> cfg_we); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        up_done |=> !up_done); // R6
    AST_SPAWN_FACE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_spawn |-> (dn_sel != '0 && dn_sel != '1)); // R2
    AST_SPAWN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_spawn |=> !dn_spawn); // R2
    AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |-> !up_ready); // R3
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD) |=> $stable({cfg_type, cfg_in0, cfg_in1, cfg_out})); // R9
endmodule

// File: tb/stem_stream_decoder_tb_top.sv
module stem_stream_decoder_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_valid = 1'b0, up_bit = 1'b0;
    logic dn_ready = 1'b0, dn_done = 1'b0;
    logic up_ready, up_done, dn_spawn, dn_valid, dn_bit, cfg_we;
    logic [2:0] dn_sel, cfg_type, cfg_in0, cfg_in1;
    logic [5:0] cfg_out;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;
    logic [14:0] cur_cfg = '0;

    always #2 clk = ~clk;

    stem_stream_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_bit(up_bit),
        .up_ready(up_ready), .up_done(up_done), .dn_sel(dn_sel),
        .dn_spawn(dn_spawn), .dn_valid(dn_valid), .dn_bit(dn_bit),
        .dn_ready(dn_ready), .dn_done(dn_done), .cfg_we(cfg_we),
        .cfg_type(cfg_type), .cfg_in0(cfg_in0), .cfg_in1(cfg_in1),
        .cfg_out(cfg_out)
    );

    function automatic logic [14:0] pack_cfg(input logic [2:0] t, input logic [2:0] a,
                                             input logic [2:0] b, input logic [5:0] m);
        return {t, a, b, m};
    endfunction

    function automatic bit is_face(input logic [2:0] c);
        return (c >= 3'd1 && c <= 3'd6);
    endfunction

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int cfg_now();
        return int'({cfg_type, cfg_in0, cfg_in1, cfg_out});
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; up_valid = 1'b0; dn_ready = 1'b0; dn_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_cfg = '0;
        #0.5;
        chk_eq("R1", "up_ready", up_ready, 1);
        chk_eq("R1", "dn_valid", dn_valid, 0);
        chk_eq("R1", "dn_spawn", dn_spawn, 0);
        chk_eq("R1", "up_done", up_done, 0);
        chk_eq("R1", "cfg_we", cfg_we, 0);
        chk_eq("R1", "cfg word", cfg_now(), 0);
    endtask

    // One bit outside relaying
    task automatic push(input logic b);
        @(negedge clk);
        up_valid = 1'b1; up_bit = b;
        #0.5;
        chk_eq("R3", "dn_valid outside relay", dn_valid, 0);
        @(posedge clk);
        #0.5;
        up_valid = 1'b0;
    endtask

    task automatic send_dir(input logic [2:0] code);
        for (int i = 2; i >= 0; i--) push(code[i]);
        if (is_face(code)) begin
            chk_eq("R2", "dn_spawn", dn_spawn, 1);
            chk_eq("R2", "dn_sel", dn_sel, code);
        end else begin
            chk_eq(code == 3'd7 ? "R5" : "R6", "dn_spawn", dn_spawn, 0);
        end
    endtask

    task automatic fwd_bit(input logic b, input int stall);
        @(negedge clk);
        up_valid = 1'b1; up_bit = b; dn_ready = (stall == 0);
        #0.5;
        chk_eq("R3", "dn_valid relay", dn_valid, 1);
        chk_eq("R3", "dn_bit relay", dn_bit, b);
        if (stall > 0) begin
            chk_eq("R3", "up_ready stalled", up_ready, 0);
            repeat (stall) @(negedge clk);
            dn_ready = 1'b1;
            #0.5;
            chk_eq("R3", "up_ready released", up_ready, 1);
        end
        @(posedge clk);
        #0.5;
        up_valid = 1'b0; dn_ready = 1'b0;
    endtask

    task automatic finish_fwd();
        @(negedge clk);
        dn_done = 1'b1; up_valid = 1'b1; up_bit = 1'b1; dn_ready = 1'b1;
        #0.5;
        chk_eq("R4", "up_ready on done", up_ready, 0);
        chk_eq("R4", "dn_valid on done", dn_valid, 0);
        @(posedge clk);
        #0.5;
        dn_done = 1'b0; up_valid = 1'b0; dn_ready = 1'b0;
        @(negedge clk);
        #0.5;
        chk_eq("R4", "back in decode", up_ready, 1);
    endtask

    task automatic send_cfg(input logic [14:0] w);
        send_dir(3'd0);
        for (int i = 14; i >= 0; i--) begin
            push(w[i]);
            if (i == 7) begin
                chk_eq("R7", "cfg held mid-word", cfg_now(), int'(cur_cfg));
                chk_eq("R7", "cfg_we mid-word", cfg_we, 0);
            end
        end
        chk_eq("R6", "cfg_we", cfg_we, 1);
        chk_eq("R6", "up_done", up_done, 1);
        chk_eq("R6", "cfg word", cfg_now(), int'(w));
        cur_cfg = w;
        @(posedge clk);
        #0.5;
        chk_eq("R6", "cfg_we pulse", cfg_we, 0);
        chk_eq("R6", "up_done pulse", up_done, 0);
        if (w[14:12] == 3'd7) chk_eq("R8", "stem returns", up_ready, 1);
        else                  chk_eq("R9", "frozen ready", up_ready, 0);
    endtask

    task automatic hold_check();
        @(negedge clk);
        up_valid = 1'b1; dn_ready = 1'b1; up_bit = 1'b1;
        repeat (4) begin
            @(negedge clk);
            #0.5;
            chk_eq("R9", "up_ready", up_ready, 0);
            chk_eq("R9", "dn_valid", dn_valid, 0);
            chk_eq("R9", "cfg stable", cfg_now(), int'(cur_cfg));
        end
        up_valid = 1'b0; dn_ready = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // Directed: discarded code 7
        send_dir(3'd7);
        @(negedge clk);
        #0.5;
        chk_eq("R5", "still decoding", up_ready, 1);
        // Directed: spawn with nothing relayed
        send_dir(3'd6);
        finish_fwd();
        // Directed: unused inputs, full mask, stem type
        send_cfg(pack_cfg(3'd7, 3'd7, 3'd7, 6'h3F));
        // Directed: new stream after stem, then a frozen XOR cell
        send_dir(3'd1);
        fwd_bit(1'b1, 2);
        fwd_bit(1'b0, 0);
        finish_fwd();
        send_cfg(pack_cfg(3'd3, 3'd2, 3'd5, 6'h21));
        hold_check();
        do_reset();

        // Random streams
        for (int it = 0; it < 40; it++) begin
            int nsub;
            logic [2:0] t;
            nsub = $urandom_range(0, 3);
            for (int s = 0; s < nsub; s++) begin
                int nb;
                send_dir(3'($urandom_range(1, 6)));
                nb = $urandom_range(0, 6);
                for (int k = 0; k < nb; k++)
                    fwd_bit(1'($urandom_range(0, 1)), $urandom_range(0, 2));
                finish_fwd();
            end
            if ($urandom_range(0, 3) == 0) begin
                send_dir(3'd7);
                @(negedge clk);
                #0.5;
                chk_eq("R5", "still decoding", up_ready, 1);
            end
            t = (it % 4 == 3) ? 3'($urandom_range(0, 6)) : 3'd7;
            send_cfg(pack_cfg(t, 3'($urandom_range(1, 7)), 3'($urandom_range(1, 7)),
                              6'($urandom_range(0, 63))));
            if (t != 3'd7) begin
                hold_check();
                do_reset();
            end
        end

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule